// File: doc/BRIEF.md
# Activity Monitor with Watermark Interrupts

This block watches one or more streams of activity events. Each channel adds a programmable weight to a period count for every cycle in which its event input is high. At the end of each sampling period, marked by a shared period strobe, the channel closes the count. It folds that count into an exponential moving average whose window length is programmable. It then compares the closed count and the new average against their own pairs of upper and lower watermarks.

Two kinds of event raise interrupt status. The first kind is the average leaving its band. The second kind is the closed count staying past a watermark for a programmed number of consecutive periods. Runs above the upper watermark and runs below the lower watermark are counted separately. Status bits are sticky until software writes ones to them. Each channel drives an interrupt line that is the OR of its enabled status bits. A small register window per channel holds the control word, the watermarks, the initial average and the count weight, and lets software read back the current average and the status. A global word shows every channel's interrupt line.

Top module: `actv_mon`

## Requirements
- R1: After reset, every control word reads 0, every count weight reads 1024 (0x400), every average and status word reads 0, the global word reads 0, and no interrupt line is high.
- R2: While control bit 31 is set, each cycle with the channel's event input high adds the count weight to the period count. The count saturates at all ones. While bit 31 is clear, events are not counted and the count is held.
- R3: A period strobe closes the period only when control bits 31 and 18 are both set. The count then restarts at the weight if the event input is high in that cycle, and at 0 otherwise. A strobe with bit 18 clear is ignored, and the count carries over into the next period.
- R4: On each period close the average becomes avg + ((count - avg) >>> (K+1)). K is control bits 12:10, and the shift is arithmetic on the signed difference, so it rounds toward minus infinity. The average reads at offset 0x20.
- R5: A write to offset 0x0C loads the average directly with the written value.
- R6: A closed count strictly above the upper watermark (offset 0x04) for N consecutive closes sets status bit 31, where N is control bits 28:26 plus one. A closed count strictly below the lower watermark (offset 0x08) for M consecutive closes sets status bit 30, where M is control bits 25:23 plus one. A run restarts from zero after a close that does not breach, and also after it fires.
- R7: At a period close, a new average strictly above the average upper watermark (offset 0x10) sets status bit 29. A new average strictly below the average lower watermark (offset 0x14) sets status bit 28.
- R8: Status bits 31:28 (offset 0x24) are sticky. Writing the status word clears exactly the bits written as one, so writing all ones clears the status.
- R9: A channel's interrupt line is high when any of these pairs has both bits set: status 31 with control 30, status 30 with control 29, status 29 with control 21, or status 28 with control 20. The global word at address 0x00 carries channel c's interrupt line in bit c.
- R10: Channel c's registers sit at address 0x40*(c+1) plus offset. Events, configuration and status of one channel leave every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_tick | input | 1 | One-cycle strobe ending a sampling period, shared by all channels |
| evt | input | NUM_CH | Activity event input, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address: the upper bits select a window, the low 6 bits an offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | NUM_CH | Per-channel interrupt line |

## Verification
The average update is swept over all eight values of K. Each value is tried with a closed count above the average and then with one below it, so rounding of positive and negative differences is told apart. The consecutive-breach logic is swept over run lengths 1 to 4 above and 1 to 3 below, with three patterns: an unbroken run, a run broken by one quiet period, and a run started right after a fire. Together these separate an off-by-one limit, a missing restart after a quiet period and a missing restart after a fire. Further patterns cover strobes with the periodic enable off, events with the master enable off, count saturation, masked and unmasked average-band status, partial status clears, and a second channel working while the first is idle.

// File: rtl/actv_mon_pkg.sv
package actv_mon_pkg;
   localparam int REG_W  = 32;
   localparam int K_W    = 3;
   localparam int RUN_W  = 3;
   localparam int OFS_W  = 6;

   // register offsets inside one channel window
   localparam logic [OFS_W-1:0] OFS_CTRL     = 6'h00;
   localparam logic [OFS_W-1:0] OFS_UP_WM    = 6'h04;
   localparam logic [OFS_W-1:0] OFS_LO_WM    = 6'h08;
   localparam logic [OFS_W-1:0] OFS_AVG_INIT = 6'h0C;
   localparam logic [OFS_W-1:0] OFS_AVG_UP   = 6'h10;
   localparam logic [OFS_W-1:0] OFS_AVG_LO   = 6'h14;
   localparam logic [OFS_W-1:0] OFS_WEIGHT   = 6'h18;
   localparam logic [OFS_W-1:0] OFS_AVG      = 6'h20;
   localparam logic [OFS_W-1:0] OFS_STAT     = 6'h24;

   // control word bit positions
   localparam int CB_EN        = 31;
   localparam int CB_RUN_UP_IE = 30;
   localparam int CB_RUN_LO_IE = 29;
   localparam int CB_RUN_UP_N  = 26;
   localparam int CB_RUN_LO_N  = 23;
   localparam int CB_AVG_UP_IE = 21;
   localparam int CB_AVG_LO_IE = 20;
   localparam int CB_PERIODIC  = 18;
   localparam int CB_K         = 10;

   // status is held as four bits mapped onto word bits 31:28
   localparam int STAT_LSB = 28;
   typedef logic [3:0] stat_vec_t;
   localparam int SI_RUN_UP = 3;
   localparam int SI_RUN_LO = 2;
   localparam int SI_AVG_UP = 1;
   localparam int SI_AVG_LO = 0;
endpackage

// File: rtl/actv_run_cnt.sv
module actv_run_cnt #(
   parameter int RUN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             breach,
   input  logic [RUN_W-1:0] limit_m1,
   output logic             fire
);
   logic [RUN_W-1:0] run_q;

   assign fire = tick & breach & (run_q == limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (tick)
         run_q <= (breach && !fire) ? run_q + RUN_W'(1) : '0;
   end

   assert_run_clear_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !breach) |=> (run_q == '0));

   assert_run_after_fire_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (run_q == '0));
endmodule

// File: rtl/actv_accum.sv
module actv_accum #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             close,
   input  logic             evt,
   input  logic [CNT_W-1:0] weight,
   output logic [CNT_W-1:0] cnt_q
);
   logic [CNT_W:0] sum;

   assign sum = {1'b0, cnt_q} + {1'b0, weight};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (close)
         cnt_q <= evt ? weight : '0;
      else if (en && evt)
         cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
   end

   assert_cnt_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !close) |=> $stable(cnt_q));

   assert_cnt_grows_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (en && !close) |=> (cnt_q >= $past(cnt_q)));

   assert_cnt_restart_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      close |=> (cnt_q == ($past(evt) ? $past(weight) : '0)));
endmodule

// File: rtl/actv_avg.sv
module actv_avg #(
   parameter int CNT_W = 32,
   parameter int K_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             upd,
   input  logic [CNT_W-1:0] sample,
   input  logic [K_W-1:0]   k,
   output logic [CNT_W-1:0] avg_q,
   output logic [CNT_W-1:0] avg_nxt
);
   logic signed [CNT_W:0] diff;
   logic signed [CNT_W:0] step;
   logic        [K_W:0]   shamt;

   assign shamt   = {1'b0, k} + (K_W+1)'(1);
   assign diff    = $signed({1'b0, sample}) - $signed({1'b0, avg_q});
   assign step    = diff >>> shamt;
   assign avg_nxt = avg_q + step[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         avg_q <= '0;
      else if (load)
         avg_q <= load_val;
      else if (upd)
         avg_q <= avg_nxt;
   end

   assert_avg_load_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (avg_q == $past(load_val)));

   assert_avg_between_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (upd && !load) |=>
         (($past(sample) >= $past(avg_q)) && (avg_q >= $past(avg_q)) && (avg_q <= $past(sample))) ||
         (($past(sample) <  $past(avg_q)) && (avg_q <= $past(avg_q)) && (avg_q >= $past(sample))));
endmodule

// File: rtl/actv_chan.sv
module actv_chan
   import actv_mon_pkg::*;
#(
   parameter int CNT_W      = 32,
   parameter int WEIGHT_RST = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             evt,
   input  logic             wr_en,
   input  logic [OFS_W-1:0] ofs,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output logic             irq
);
   logic [REG_W-1:0] ctrl_q;
   logic [CNT_W-1:0] up_wm_q, lo_wm_q, init_q, aup_q, alo_q, weight_q;
   logic [CNT_W-1:0] sample, avg_q, avg_nxt;
   stat_vec_t        stat_q, stat_set, stat_clr, stat_ie;
   logic             period, avg_load;
   logic [1:0]       breach, fire;
   logic [RUN_W-1:0] limit_m1 [2];

   assign period   = tick & ctrl_q[CB_EN] & ctrl_q[CB_PERIODIC];
   assign avg_load = wr_en && (ofs == OFS_AVG_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         up_wm_q  <= '0;
         lo_wm_q  <= '0;
         init_q   <= '0;
         aup_q    <= '0;
         alo_q    <= '0;
         weight_q <= CNT_W'(WEIGHT_RST);
      end else if (wr_en) begin
         case (ofs)
            OFS_CTRL:     ctrl_q   <= wdata;
            OFS_UP_WM:    up_wm_q  <= wdata[CNT_W-1:0];
            OFS_LO_WM:    lo_wm_q  <= wdata[CNT_W-1:0];
            OFS_AVG_INIT: init_q   <= wdata[CNT_W-1:0];
            OFS_AVG_UP:   aup_q    <= wdata[CNT_W-1:0];
            OFS_AVG_LO:   alo_q    <= wdata[CNT_W-1:0];
            OFS_WEIGHT:   weight_q <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   actv_accum #(.CNT_W(CNT_W)) i_accum (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_EN]), .close(period),
      .evt(evt), .weight(weight_q), .cnt_q(sample));

   actv_avg #(.CNT_W(CNT_W), .K_W(K_W)) i_avg (
      .clk(clk), .rst_n(rst_n), .load(avg_load), .load_val(wdata[CNT_W-1:0]),
      .upd(period), .sample(sample), .k(ctrl_q[CB_K +: K_W]),
      .avg_q(avg_q), .avg_nxt(avg_nxt));

   // index 0: run above the upper watermark, index 1: run below the lower one
   assign breach[0]   = sample > up_wm_q;
   assign breach[1]   = sample < lo_wm_q;
   assign limit_m1[0] = ctrl_q[CB_RUN_UP_N +: RUN_W];
   assign limit_m1[1] = ctrl_q[CB_RUN_LO_N +: RUN_W];

   for (genvar g = 0; g < 2; g++) begin : g_run
      actv_run_cnt #(.RUN_W(RUN_W)) i_run (
         .clk(clk), .rst_n(rst_n), .tick(period), .breach(breach[g]),
         .limit_m1(limit_m1[g]), .fire(fire[g]));
   end

   always_comb begin
      stat_set            = '0;
      stat_set[SI_RUN_UP] = fire[0];
      stat_set[SI_RUN_LO] = fire[1];
      stat_set[SI_AVG_UP] = period && (avg_nxt > aup_q);
      stat_set[SI_AVG_LO] = period && (avg_nxt < alo_q);
      stat_clr            = (wr_en && ofs == OFS_STAT) ? wdata[STAT_LSB +: 4] : '0;
      stat_ie[SI_RUN_UP]  = ctrl_q[CB_RUN_UP_IE];
      stat_ie[SI_RUN_LO]  = ctrl_q[CB_RUN_LO_IE];
      stat_ie[SI_AVG_UP]  = ctrl_q[CB_AVG_UP_IE];
      stat_ie[SI_AVG_LO]  = ctrl_q[CB_AVG_LO_IE];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stat_q <= '0;
      else
         stat_q <= (stat_q & ~stat_clr) | stat_set;
   end

   assign irq = |(stat_q & stat_ie);

   always_comb begin
      case (ofs)
         OFS_CTRL:     rdata = ctrl_q;
         OFS_UP_WM:    rdata = REG_W'(up_wm_q);
         OFS_LO_WM:    rdata = REG_W'(lo_wm_q);
         OFS_AVG_INIT: rdata = REG_W'(init_q);
         OFS_AVG_UP:   rdata = REG_W'(aup_q);
         OFS_AVG_LO:   rdata = REG_W'(alo_q);
         OFS_WEIGHT:   rdata = REG_W'(weight_q);
         OFS_AVG:      rdata = REG_W'(avg_q);
         OFS_STAT:     rdata = {stat_q, {STAT_LSB{1'b0}}};
         default:      rdata = '0;
      endcase
   end

   assert_stat_w1c_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ofs == OFS_STAT && wdata[REG_W-1:STAT_LSB] == 4'hF && !period) |=> (stat_q == '0));

   assert_stat_sticky_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && ofs == OFS_STAT) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   assert_stat_needs_close_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (!period && !(wr_en && ofs == OFS_STAT)) |=> $stable(stat_q));
endmodule

// File: rtl/actv_mon.sv
module actv_mon
   import actv_mon_pkg::*;
#(
   parameter int NUM_CH     = 2,
   parameter int CNT_W      = 32,
   parameter int ADDR_W     = 8,
   parameter int WEIGHT_RST = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              period_tick,
   input  logic [NUM_CH-1:0] evt,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic [NUM_CH-1:0] irq
);
   localparam int WIN_W = ADDR_W - OFS_W;

   if (WIN_W < 1 || NUM_CH < 1 || NUM_CH + 1 > (1 << WIN_W) || NUM_CH > REG_W)
      $error("actv_mon: address space too small for NUM_CH");
   if (CNT_W < 2 || CNT_W > REG_W)
      $error("actv_mon: CNT_W must lie in 2..32");
   if ((longint'(WEIGHT_RST) >> CNT_W) != 0)
      $error("actv_mon: WEIGHT_RST does not fit CNT_W");

   logic [WIN_W-1:0] win;
   logic [OFS_W-1:0] ofs;
   logic [REG_W-1:0] ch_rdata [NUM_CH];

   assign win = reg_addr[ADDR_W-1:OFS_W];
   assign ofs = reg_addr[OFS_W-1:0];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      actv_chan #(.CNT_W(CNT_W), .WEIGHT_RST(WEIGHT_RST)) i_chan (
         .clk(clk), .rst_n(rst_n), .tick(period_tick), .evt(evt[c]),
         .wr_en(reg_we && (win == WIN_W'(c + 1))), .ofs(ofs),
         .wdata(reg_wdata), .rdata(ch_rdata[c]), .irq(irq[c]));
   end

   always_comb begin
      reg_rdata = '0;
      if (win == '0 && ofs == '0)
         reg_rdata = REG_W'(irq);
      for (int c = 0; c < NUM_CH; c++)
         if (win == WIN_W'(c + 1))
            reg_rdata = ch_rdata[c];
   end
endmodule

// File: tb/test_actv_mon.sv
`timescale 1ns/1ps
module test_actv_mon;
   localparam logic [31:0] C_EN     = 32'h8000_0000;
   localparam logic [31:0] C_PER    = 32'h0004_0000;
   localparam logic [31:0] C_RUP_IE = 32'h4000_0000;
   localparam logic [31:0] C_RLO_IE = 32'h2000_0000;
   localparam logic [31:0] C_AUP_IE = 32'h0020_0000;
   localparam logic [31:0] C_ALO_IE = 32'h0010_0000;
   localparam logic [7:0]  CH0 = 8'h40;
   localparam logic [7:0]  CH1 = 8'h80;

   logic        clk = 0, rst_n = 0, tick = 0, we = 0;
   logic [1:0]  evt = '0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [1:0]  irq;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   actv_mon i_actv_mon (
      .clk(clk), .rst_n(rst_n), .period_tick(tick), .evt(evt),
      .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1;
      @(negedge clk); we = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic pulses(input int ch, input int n);
      repeat (n) begin @(negedge clk); evt[ch] = 1; end
      @(negedge clk); evt[ch] = 0;
   endtask

   task automatic period(input int ch, input int n);
      pulses(ch, n);
      tick = 1;
      @(negedge clk); tick = 0;
   endtask

   function automatic longint avg_step(input longint a, input longint s, input int k);
      return a + ((s - a) >>> (k + 1));
   endfunction

   task automatic report;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      longint m;
      repeat (4) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      rd(CH0 + 8'h00, v); chk("R1 ctrl", v, 0);
      rd(CH0 + 8'h18, v); chk("R1 weight", v, 32'h400);
      rd(CH0 + 8'h20, v); chk("R1 avg", v, 0);
      rd(CH0 + 8'h24, v); chk("R1 status", v, 0);
      rd(CH1 + 8'h18, v); chk("R1 weight ch1", v, 32'h400);
      rd(8'h00, v);       chk("R1 global", v, 0);
      chk("R1 irq", {30'b0, irq}, 0);

      // R5 direct load; R3 strobe ignored without periodic enable
      wr(CH0 + 8'h0C, 100);
      rd(CH0 + 8'h20, v); chk("R5 load", v, 100);
      wr(CH0 + 8'h18, 5);
      wr(CH0 + 8'h00, C_EN);
      period(0, 7);
      rd(CH0 + 8'h20, v); chk("R3 strobe ignored", v, 100);
      wr(CH0 + 8'h00, C_EN | C_PER);
      period(0, 0);
      m = avg_step(100, 35, 0);
      rd(CH0 + 8'h20, v); chk("R3 count carried", v, 32'(m));
      // R2 master enable off: events dropped
      wr(CH0 + 8'h00, 0);
      pulses(0, 4);
      wr(CH0 + 8'h00, C_EN | C_PER);
      period(0, 0);
      m = avg_step(m, 0, 0);
      rd(CH0 + 8'h20, v); chk("R2 disabled count", v, 32'(m));
      // R2 saturation
      wr(CH0 + 8'h18, 32'hFFFF_FFFF);
      wr(CH0 + 8'h0C, 0);
      period(0, 3);
      rd(CH0 + 8'h20, v); chk("R2 saturate", v, 32'h7FFF_FFFF);

      // R4 sweep over K with rising and falling samples
      wr(CH0 + 8'h18, 100);
      for (int k = 0; k < 8; k++) begin
         wr(CH0 + 8'h00, C_EN | C_PER | (32'(k) << 10));
         wr(CH0 + 8'h0C, 1000);
         period(0, 30);
         m = avg_step(1000, 3000, k);
         rd(CH0 + 8'h20, v); chk($sformatf("R4 rise k=%0d", k), v, 32'(m));
         period(0, 0);
         m = avg_step(m, 0, k);
         rd(CH0 + 8'h20, v); chk($sformatf("R4 fall k=%0d", k), v, 32'(m));
      end

      // R6 consecutive runs above the upper watermark
      wr(CH0 + 8'h04, 50);
      wr(CH0 + 8'h08, 0);
      wr(CH0 + 8'h10, 32'hFFFF_FFFF);
      wr(CH0 + 8'h14, 0);
      for (int n = 1; n <= 4; n++) begin
         wr(CH0 + 8'h00, C_EN | C_PER | C_RUP_IE | (32'(n - 1) << 26));
         period(0, 0);
         wr(CH0 + 8'h24, 32'hFFFF_FFFF);
         for (int i = 0; i < n - 1; i++) period(0, 1);
         rd(CH0 + 8'h24, v); chk($sformatf("R6 up short n=%0d", n), v, 0);
         period(0, 1);
         rd(CH0 + 8'h24, v); chk($sformatf("R6 up fire n=%0d", n), v, 32'h8000_0000);
         chk($sformatf("R9 up irq n=%0d", n), {31'b0, irq[0]}, 1);
         wr(CH0 + 8'h24, 32'hFFFF_FFFF);
         rd(CH0 + 8'h24, v); chk($sformatf("R8 clear n=%0d", n), v, 0);
         chk($sformatf("R9 irq low n=%0d", n), {31'b0, irq[0]}, 0);
         if (n > 1) begin
            for (int i = 0; i < n - 1; i++) period(0, 1);
            rd(CH0 + 8'h24, v); chk($sformatf("R6 restart after fire n=%0d", n), v, 0);
            period(0, 0);
            for (int i = 0; i < n - 1; i++) period(0, 1);
            rd(CH0 + 8'h24, v); chk($sformatf("R6 broken run n=%0d", n), v, 0);
            period(0, 1);
            rd(CH0 + 8'h24, v); chk($sformatf("R6 refire n=%0d", n), v, 32'h8000_0000);
            wr(CH0 + 8'h24, 32'hFFFF_FFFF);
         end
      end

      // R6 consecutive runs below the lower watermark
      wr(CH0 + 8'h04, 32'hFFFF_FFFF);
      wr(CH0 + 8'h08, 50);
      for (int n = 1; n <= 3; n++) begin
         wr(CH0 + 8'h00, C_EN | C_PER | C_RLO_IE | (32'(n - 1) << 23));
         period(0, 1);
         wr(CH0 + 8'h24, 32'hFFFF_FFFF);
         for (int i = 0; i < n - 1; i++) period(0, 0);
         rd(CH0 + 8'h24, v); chk($sformatf("R6 lo short n=%0d", n), v, 0);
         period(0, 0);
         rd(CH0 + 8'h24, v); chk($sformatf("R6 lo fire n=%0d", n), v, 32'h4000_0000);
         chk($sformatf("R9 lo irq n=%0d", n), {31'b0, irq[0]}, 1);
         wr(CH0 + 8'h24, 32'hFFFF_FFFF);
         if (n > 1) begin
            for (int i = 0; i < n - 1; i++) period(0, 0);
            period(0, 1);
            for (int i = 0; i < n - 1; i++) period(0, 0);
            rd(CH0 + 8'h24, v); chk($sformatf("R6 lo broken n=%0d", n), v, 0);
            wr(CH0 + 8'h24, 32'hFFFF_FFFF);
         end
      end

      // R7 average band, R9 masking, R8 partial clear
      wr(CH0 + 8'h08, 0);
      wr(CH0 + 8'h10, 500);
      wr(CH0 + 8'h14, 200);
      wr(CH0 + 8'h0C, 300);
      wr(CH0 + 8'h24, 32'hFFFF_FFFF);
      wr(CH0 + 8'h00, C_EN | C_PER | C_ALO_IE);
      period(0, 10);
      m = avg_step(300, 1000, 0);
      rd(CH0 + 8'h20, v); chk("R4 band avg", v, 32'(m));
      rd(CH0 + 8'h24, v); chk("R7 above band", v, 32'h2000_0000);
      chk("R9 masked", {31'b0, irq[0]}, 0);
      period(0, 0);
      m = avg_step(m, 0, 0);
      rd(CH0 + 8'h24, v); chk("R7 inside band", v, 32'h2000_0000);
      period(0, 0);
      m = avg_step(m, 0, 0);
      rd(CH0 + 8'h20, v); chk("R4 band avg low", v, 32'(m));
      rd(CH0 + 8'h24, v); chk("R7 below band", v, 32'h3000_0000);
      chk("R9 enabled", {31'b0, irq[0]}, 1);
      rd(8'h00, v); chk("R9 global ch0", v, 1);
      wr(CH0 + 8'h24, 32'h1000_0000);
      rd(CH0 + 8'h24, v); chk("R8 partial clear", v, 32'h2000_0000);
      chk("R9 after clear", {31'b0, irq[0]}, 0);

      // R10 second channel alone
      wr(CH0 + 8'h00, 0);
      wr(CH1 + 8'h18, 7);
      wr(CH1 + 8'h04, 32'hFFFF_FFFF);
      wr(CH1 + 8'h10, 10);
      wr(CH1 + 8'h00, C_EN | C_PER | C_AUP_IE);
      period(1, 4);
      rd(CH1 + 8'h20, v); chk("R10 ch1 avg", v, 32'(avg_step(0, 28, 0)));
      rd(CH1 + 8'h24, v); chk("R10 ch1 status", v, 32'h2000_0000);
      rd(CH0 + 8'h20, v); chk("R10 ch0 avg kept", v, 32'(m));
      rd(CH0 + 8'h24, v); chk("R10 ch0 status kept", v, 32'h2000_0000);
      rd(8'h00, v); chk("R9 global ch1", v, 2);

      done = 1;
      report();
      $finish;
   end
endmodule